// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers sixteen level-sensitive interrupt requests from peripherals and presents them to one processor as a single interrupt line. Software controls which requests may reach the processor through a per-source enable mask. The mask is never written as a whole word. One register offset turns on the bits written as 1, and a second offset turns off the bits written as 1. Two pieces of code can therefore change different sources without a read-modify-write sequence. Software sets all sixteen bits at the turn-off offset to mask everything at start-up.

Each request line passes through a two-flop synchronizer. A status word shows which enabled requests are high at that moment. The request is not latched: a source stops being pending as soon as its line drops. The enabled, pending requests are ORed into a registered interrupt output. Software picks the source to serve by scanning the status word, for example for its highest set bit. Accesses use a plain synchronous port with a byte address, 32-bit write data, a write strobe and combinational read data.

Top module: `lvlirq_ctrl`

## Requirements
- R1: After reset the enable mask is all zero, the status word reads zero and `irq_o` is low.
- R2: A write to offset 0x08 sets every enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. A read of 0x08 returns the enable mask in bits 15:0.
- R3: A write to offset 0x0C clears every enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. A read of 0x0C returns zero.
- R4: A read of offset 0x00 returns the synchronized request lines ANDed with the enable mask in bits 15:0. A write to 0x00 changes nothing.
- R5: Read data bits 31:16 are always zero. Write-data bits 31:16 have no effect at 0x08 or 0x0C.
- R6: Requests are level-sensitive. A status bit is high only while its request line is high, and it returns to zero after the line drops, with no latching.
- R7: `irq_o` is the registered OR of the status bits. A change on a request line sampled at a rising edge reaches status after the second rising edge and `irq_o` after the third. A mask write reaches `irq_o` one rising edge after the write edge.
- R8: Reads of any other offset return zero, and writes to them leave the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Level interrupt request lines, asynchronous |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The mask is driven with set and clear words whose zero bits must leave other bits untouched. Overlapping and disjoint patterns show whether an update is a true per-bit set or clear, as opposed to a word overwrite. Request lines are raised with the mask closed, partly open and fully open, which separates masking from synchronizing. Each request is then dropped again to show it is not held. Samples taken one edge before and one edge on the expected latency pin the synchronizer and output register depths. Bit 15, all-ones words with the upper half set, and the unmapped and read-only offsets cover the edges of the register map.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;

    localparam int unsigned LI_ADDR_W = 8;

    typedef logic [LI_ADDR_W-1:0] li_addr_t;

    // register offsets seen by software
    localparam li_addr_t LI_OFS_STATUS = 8'h00;
    localparam li_addr_t LI_OFS_EN_SET = 8'h08;
    localparam li_addr_t LI_OFS_EN_CLR = 8'h0C;

    typedef enum logic [1:0] {
        LI_SEL_NONE,
        LI_SEL_STATUS,
        LI_SEL_SET,
        LI_SEL_CLR
    } li_sel_e;

    function automatic li_sel_e li_decode(li_addr_t addr);
        li_sel_e sel;
        case (addr)
            LI_OFS_STATUS: sel = LI_SEL_STATUS;
            LI_OFS_EN_SET: sel = LI_SEL_SET;
            LI_OFS_EN_CLR: sel = LI_SEL_CLR;
            default:       sel = LI_SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/lvlirq_sync.sv
module lvlirq_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/lvlirq_regs.sv
module lvlirq_regs
    import lvlirq_pkg::*;
#(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  li_sel_e           sel_i,
    input  logic              wr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic [NSRC-1:0]   lvl_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   status_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NSRC-1:0] en;
    } regs_st_t;

    regs_st_t st_d, st_q;

    // next-state: per-bit set or clear, never a whole-word load
    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (sel_i)
                LI_SEL_SET: st_d.en = st_q.en | wdata_i;
                LI_SEL_CLR: st_d.en = st_q.en & ~wdata_i;
                default:    st_d.en = st_q.en;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign status_o = lvl_i & st_q.en;

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            LI_SEL_STATUS: rdata_o[NSRC-1:0] = status_o;
            LI_SEL_SET:    rdata_o[NSRC-1:0] = st_q.en;
            default:       rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/lvlirq_out.sv
module lvlirq_out #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_i,
    output logic            irq_o
);

    typedef struct packed {
        logic irq;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |status_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/lvlirq_ctrl.sv
module lvlirq_ctrl
    import lvlirq_pkg::*;
#(
    parameter int unsigned NSRC        = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_i,
    input  logic [LI_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    input  logic                 bus_wr_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o
);

    li_sel_e         bus_sel;
    logic [NSRC-1:0] src_sync;
    logic [NSRC-1:0] en_mask;
    logic [NSRC-1:0] status_vec;
    logic            unused_wdata_hi;

    assign bus_sel         = li_decode(bus_addr_i);
    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NSRC];

    lvlirq_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    lvlirq_regs #(
        .NSRC   (NSRC),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel),
        .wr_i     (bus_wr_i),
        .wdata_i  (bus_wdata_i[NSRC-1:0]),
        .lvl_i    (src_sync),
        .en_o     (en_mask),
        .status_o (status_vec),
        .rdata_o  (bus_rdata_o)
    );

    lvlirq_out #(
        .NSRC (NSRC)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_vec),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/lvlirq_ctrl_chk.sv
module lvlirq_ctrl_chk
    import lvlirq_pkg::*;
#(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LI_ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 wr,
    input logic [DATA_W-1:0]    rdata,
    input logic [NSRC-1:0]      en,
    input logic [NSRC-1:0]      stat,
    input logic                 irq
);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == LI_OFS_EN_SET) |=>
            ((en & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == LI_OFS_EN_CLR) |=>
            ((en & $past(wdata[NSRC-1:0])) == '0));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == LI_OFS_EN_SET || addr == LI_OFS_EN_CLR)) |=> $stable(en));

    // R7
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|$past(stat))));

    // R3
    clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == LI_OFS_EN_CLR) |-> (rdata == '0));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rdata[DATA_W-1:NSRC] == '0));

endmodule

bind lvlirq_ctrl lvlirq_ctrl_chk #(
    .NSRC   (NSRC),
    .DATA_W (DATA_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .wr    (bus_wr_i),
    .rdata (bus_rdata_o),
    .en    (en_mask),
    .stat  (status_vec),
    .irq   (irq_o)
);

// File: tb/lvlirq_ctrl_tb_top.sv
`timescale 1ns/10ps
module lvlirq_ctrl_tb_top;

    localparam logic [7:0] A_STAT  = 8'h00;
    localparam logic [7:0] A_SET   = 8'h08;
    localparam logic [7:0] A_CLR   = 8'h0C;
    localparam logic [7:0] A_IDLE  = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic [7:0]  bus_addr = A_IDLE;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    lvlirq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_wr_i    (bus_wr),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            #0.1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                             it.is_irq ? "irq" : "rdata", act, it.exp);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr    = 1'b0;
        bus_addr  = A_IDLE;
    endtask

    task automatic exp_rd(logic [7:0] a, logic [31:0] e, string tag);
        sb_item_t it;
        bus_addr  = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic exp_irq(logic e, string tag);
        sb_item_t it;
        it.is_irq = 1'b1;
        it.exp    = {31'b0, e};
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_irq(1'b0, "R1");
        exp_rd(A_SET, 32'h0, "R1");
        exp_rd(A_STAT, 32'h0, "R1");

        // R4 requests high but mask closed
        src = 16'hFFFF;
        tick(3);
        exp_rd(A_STAT, 32'h0, "R4");
        exp_irq(1'b0, "R4");

        // R2 set two bits; R7 irq one edge after the mask write
        bus_write(A_SET, 32'h0000_0005);
        exp_rd(A_SET, 32'h0000_0005, "R2");
        exp_rd(A_STAT, 32'h0000_0005, "R4");
        exp_irq(1'b0, "R7");
        tick(1);
        exp_irq(1'b1, "R7");

        // R2 zero bits leave the mask alone; set adds without clearing
        bus_write(A_SET, 32'h0);
        exp_rd(A_SET, 32'h0000_0005, "R2");
        bus_write(A_SET, 32'h0000_0002);
        exp_rd(A_SET, 32'h0000_0007, "R2");

        // R3 clear one bit, others stay; clear offset reads zero
        bus_write(A_CLR, 32'h0000_0001);
        exp_rd(A_SET, 32'h0000_0006, "R3");
        exp_rd(A_CLR, 32'h0, "R3");
        exp_rd(A_STAT, 32'h0000_0006, "R4");

        // R8 unmapped offsets; R4 status is read-only
        bus_write(8'h04, 32'hFFFF_FFFF);
        exp_rd(A_SET, 32'h0000_0006, "R8");
        exp_rd(8'h04, 32'h0, "R8");
        bus_write(8'h10, 32'h0000_FFFF);
        exp_rd(A_SET, 32'h0000_0006, "R8");
        bus_write(A_STAT, 32'h0000_FFFF);
        exp_rd(A_SET, 32'h0000_0006, "R4");

        // R7 input latency: status after 2nd edge, irq after 3rd
        src = 16'h0000;
        tick(1);
        exp_rd(A_STAT, 32'h0000_0006, "R7");
        tick(1);
        exp_rd(A_STAT, 32'h0, "R7");
        exp_irq(1'b1, "R7");
        tick(1);
        exp_irq(1'b0, "R7");

        // R6 level, no latching
        src = 16'h0004;
        tick(3);
        exp_rd(A_STAT, 32'h0000_0004, "R6");
        exp_irq(1'b1, "R6");
        src = 16'h0000;
        tick(3);
        exp_rd(A_STAT, 32'h0, "R6");
        exp_irq(1'b0, "R6");

        // R5 upper bits read zero and have no effect
        bus_write(A_SET, 32'hFFFF_FFFF);
        exp_rd(A_SET, 32'h0000_FFFF, "R5");
        src = 16'hFFFF;
        tick(3);
        exp_rd(A_STAT, 32'h0000_FFFF, "R5");
        bus_write(A_CLR, 32'hFFFF_0000);
        exp_rd(A_SET, 32'h0000_FFFF, "R5");

        // R3 mask everything
        bus_write(A_CLR, 32'h0000_FFFF);
        exp_rd(A_SET, 32'h0, "R3");
        exp_rd(A_STAT, 32'h0, "R3");
        tick(1);
        exp_irq(1'b0, "R3");

        // R7 top bit alone drives irq
        src = 16'h8000;
        tick(3);
        bus_write(A_SET, 32'h0000_8000);
        exp_rd(A_STAT, 32'h0000_8000, "R4");
        tick(1);
        exp_irq(1'b1, "R7");

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule